// File: doc/BRIEF.md
# Interrupt Enable and Request Controller

This block sits beside a small 4-bit processor core and manages seven interrupt sources: two external pins, four timers and an analog-to-digital converter. Each source has a request flag that a one-cycle pulse from its peripheral sets. Two 4-bit enable banks decide, per source, whether its request is delivered as an interrupt or left for software to poll with a skip-on-request test. Software writes and reads both enable banks only through the 4-bit accumulator, using write and read strobes.

A source becomes eligible when its request flag, its enable bit and the global interrupt-enable flag are all set. When a source becomes eligible, the block waits a delay that depends on the length of the instruction running at that moment, then issues a one-cycle interrupt pulse with the index of the winning source. The same edge clears the winner's flag and the global enable. Each clock cycle of the block is one machine cycle of the core.

Top module: `irq_ctrl`

## Requirements
- R1: After reset both enable banks read 0000, no request flag is set, the global enable is 0 and `irq_o` is 0.
- R2: The low bank holds source enables: bit 0 external 0 (index 0), bit 1 external 1 (index 1), bit 2 timer 1 (index 2), bit 3 timer 2 (index 3). It is loaded from `acc_i` on `wr_lo_i` and returned on `acc_o` while `rd_lo_i` is high.
- R3: The high bank holds bit 0 timer 3 (index 4), bit 1 timer 4 (index 5), bit 2 converter (index 6). It uses `wr_hi_i`/`rd_hi_i`. Bit 3 drives nothing but is written and read back like the others. Writing one bank leaves the other unchanged.
- R4: `retain_i` clears both banks to 0000 and wins over a write in the same cycle.
- R5: No interrupt is issued unless the global enable, the source's enable bit and its request flag are all 1.
- R6: With `multi_i` low in the first cycle in which a source is eligible, `irq_o` is high 2 cycles later.
- R7: With `multi_i` high in that first eligible cycle, `irq_o` is high 3 cycles later.
- R8: When a source's enable bit is 0, `skip_o` is high during a `skip_req_i` cycle for that source (`skip_src_i` = its index) exactly when its flag is set. A skip that reports 1 clears the flag.
- R9: When a source's enable bit is 1, `skip_o` stays 0 for that source and its flag is kept.
- R10: If several sources are eligible at the issue edge, the lowest index wins. `vector_o` carries that index while `irq_o` is high.
- R11: `irq_o` lasts one cycle. The issuing edge clears the global enable and the winner's flag. Other flags are kept.
- R12: A one-cycle pulse on `req_i[k]` sets flag k, and the flag stays set until it is cleared by R8 or R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retain_i | input | 1 | Low-power retention entry; clears enable banks |
| acc_i | input | 4 | Accumulator value for bank writes |
| wr_lo_i | input | 1 | Load low enable bank from accumulator |
| wr_hi_i | input | 1 | Load high enable bank from accumulator |
| rd_lo_i | input | 1 | Drive low enable bank onto `acc_o` |
| rd_hi_i | input | 1 | Drive high enable bank onto `acc_o` |
| acc_o | output | 4 | Bank read data (0 when no read strobe) |
| req_i | input | 7 | Request pulses from the peripherals, by source index |
| gie_set_i | input | 1 | Set the global interrupt enable |
| gie_clr_i | input | 1 | Clear the global interrupt enable |
| multi_i | input | 1 | Current instruction takes more than one cycle |
| skip_req_i | input | 1 | Skip-on-request test strobe |
| skip_src_i | input | 3 | Source index of the skip test |
| skip_o | output | 1 | Skip-test result |
| irq_o | output | 1 | One-cycle interrupt issue pulse |
| vector_o | output | 3 | Index of the issued source |

## Verification
The hardest case to reach from the ports is two sources eligible at the same issue edge, with the loser still pending afterwards. The bench sets both request pulses in one cycle with the global enable already on. It checks that the lower index is issued first. It then sets the global enable again and checks that the loser follows after the normal delay. Whether a flag was cleared is observed through the normal interface: the source's enable bit is turned off and a skip test is run, so the test reports the flag that the interrupt path would otherwise hide.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int SRC_COUNT  = 7;
    localparam int ACC_WIDTH  = 4;
    localparam int SHORT_WAIT = 2;
    localparam int LONG_WAIT  = 3;

    typedef enum logic [2:0] {
        SRC_EXT0  = 3'd0,
        SRC_EXT1  = 3'd1,
        SRC_TMR1  = 3'd2,
        SRC_TMR2  = 3'd3,
        SRC_TMR3  = 3'd4,
        SRC_TMR4  = 3'd5,
        SRC_ADC   = 3'd6
    } src_e;
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
    parameter int DAT_W = 4,
    parameter int NSRC  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retain_i,
    input  logic [DAT_W-1:0] acc_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    output logic [DAT_W-1:0] acc_o,
    output logic [NSRC-1:0]  en_o
);
    typedef struct packed {
        logic [DAT_W-1:0] hi;
        logic [DAT_W-1:0] lo;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (retain_i) begin
            bank_d = '0;
        end else begin
            if (wr_lo_i) bank_d.lo = acc_i;
            if (wr_hi_i) bank_d.hi = acc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        if (rd_lo_i)      acc_o = bank_q.lo;
        else if (rd_hi_i) acc_o = bank_q.hi;
        else              acc_o = '0;
    end

    assign en_o = NSRC'(bank_q);
endmodule

// File: rtl/irq_req_flags.sv
module irq_req_flags #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);
    logic [NSRC-1:0] flag_d, flag_q;

    for (genvar k = 0; k < NSRC; k++) begin : g_flag
        assign flag_d[k] = set_i[k] | (flag_q[k] & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC  = 7,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]  cand_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [NSRC-1:0]  win_o
);
    assign any_o = |cand_i;
    assign win_o = cand_i & (~cand_i + NSRC'(1));

    always_comb begin
        idx_o = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (cand_i[k]) idx_o = IDX_W'(k);
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC      = SRC_COUNT,
    parameter int DAT_W     = ACC_WIDTH,
    parameter int SHORT_DLY = SHORT_WAIT,
    parameter int LONG_DLY  = LONG_WAIT,
    localparam int IDX_W    = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retain_i,
    input  logic [DAT_W-1:0] acc_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    output logic [DAT_W-1:0] acc_o,
    input  logic [NSRC-1:0]  req_i,
    input  logic             gie_set_i,
    input  logic             gie_clr_i,
    input  logic             multi_i,
    input  logic             skip_req_i,
    input  logic [IDX_W-1:0] skip_src_i,
    output logic             skip_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] vector_o
);
    localparam int CNT_W = $clog2(LONG_DLY + 1);
    localparam int NPAD  = 1 << IDX_W;

    typedef struct packed {
        logic             gie;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic [IDX_W-1:0] vec;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NSRC-1:0]  en_w, flag_w, cand_w, win_w, clr_w, skip_clr_w;
    logic [NPAD-1:0]  en_pad, flag_pad;
    logic             any_w, take_w, gie_w;
    logic [IDX_W-1:0] win_idx_w;

    irq_en_bank #(.DAT_W(DAT_W), .NSRC(NSRC)) bank_i (
        .clk(clk), .rst_n(rst_n), .retain_i(retain_i), .acc_i(acc_i),
        .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
        .acc_o(acc_o), .en_o(en_w)
    );

    irq_req_flags #(.NSRC(NSRC)) flags_i (
        .clk(clk), .rst_n(rst_n), .set_i(req_i), .clr_i(clr_w), .flag_o(flag_w)
    );

    assign cand_w = flag_w & en_w & {NSRC{seq_q.gie}};

    irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) arb_i (
        .cand_i(cand_w), .any_o(any_w), .idx_o(win_idx_w), .win_o(win_w)
    );

    // Polled path: valid only for sources whose enable bit is clear
    assign en_pad   = NPAD'(en_w);
    assign flag_pad = NPAD'(flag_w);
    assign skip_o   = skip_req_i && (int'(skip_src_i) < NSRC)
                      && flag_pad[skip_src_i] && !en_pad[skip_src_i];

    always_comb begin
        skip_clr_w = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (skip_o && (int'(skip_src_i) == k)) skip_clr_w[k] = 1'b1;
        end
    end

    // Delay sequencer: a count of 1 marks the issue edge
    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = 1'b0;
        take_w    = 1'b0;
        if (!any_w) begin
            seq_d.cnt = '0;
        end else if (seq_q.cnt == '0) begin
            seq_d.cnt = multi_i ? CNT_W'(LONG_DLY - 1) : CNT_W'(SHORT_DLY - 1);
        end else if (seq_q.cnt == CNT_W'(1)) begin
            take_w    = 1'b1;
            seq_d.irq = 1'b1;
            seq_d.vec = win_idx_w;
            seq_d.cnt = '0;
        end else begin
            seq_d.cnt = seq_q.cnt - CNT_W'(1);
        end

        if (take_w)         seq_d.gie = 1'b0;
        else if (gie_set_i) seq_d.gie = 1'b1;
        else if (gie_clr_i) seq_d.gie = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign clr_w    = (take_w ? win_w : '0) | skip_clr_w;
    assign gie_w    = seq_q.gie;
    assign irq_o    = seq_q.irq;
    assign vector_o = seq_q.vec;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int NSRC  = 7,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retain_i,
    input logic             irq_i,
    input logic [IDX_W-1:0] vec_i,
    input logic             gie_i,
    input logic [NSRC-1:0]  en_i,
    input logic             skip_i,
    input logic [IDX_W-1:0] skip_src_i
);
    localparam int NPAD = 1 << IDX_W;
    logic [NPAD-1:0] en_pad;
    assign en_pad = NPAD'(en_i);

    // R11: the issue pulse is a single cycle
    assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> !irq_i);

    // R11: global enable is already cleared while the pulse is out
    assert_gie_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> !gie_i);

    // R5: global enable was on in the cycle before issue
    assert_gie_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> $past(gie_i));

    // R9: a set enable bit forbids the polled skip
    assert_skip_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip_i |-> !en_pad[skip_src_i]);

    // R10: issued index names a real source
    assert_vec_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> (int'(vec_i) < NSRC));

    // R4: retention entry leaves every enable bit clear
    assert_retain_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retain_i |=> (en_i == '0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .retain_i(retain_i), .irq_i(irq_o), .vec_i(vector_o),
    .gie_i(gie_w), .en_i(en_w), .skip_i(skip_o), .skip_src_i(skip_src_i)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retain_i = 1'b0;
    logic [3:0] acc_i = '0;
    logic       wr_lo_i = 1'b0, wr_hi_i = 1'b0, rd_lo_i = 1'b0, rd_hi_i = 1'b0;
    logic [3:0] acc_o;
    logic [6:0] req_i = '0;
    logic       gie_set_i = 1'b0, gie_clr_i = 1'b0, multi_i = 1'b0;
    logic       skip_req_i = 1'b0;
    logic [2:0] skip_src_i = '0;
    logic       skip_o, irq_o;
    logic [2:0] vector_o;

    always #5 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .retain_i(retain_i), .acc_i(acc_i),
        .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
        .acc_o(acc_o), .req_i(req_i), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
        .multi_i(multi_i), .skip_req_i(skip_req_i), .skip_src_i(skip_src_i),
        .skip_o(skip_o), .irq_o(irq_o), .vector_o(vector_o)
    );

    typedef struct {
        int    at;
        int    vec;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected interrupts and compares cycle and index
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb_q.size() > 0 && cyc > sb_q[0].at) begin
                check(1'b0, {sb_q[0].tag, " missing irq at cycle"}, cyc, sb_q[0].at);
                void'(sb_q.pop_front());
            end
            if (irq_o) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5 unexpected irq vector", int'(vector_o), -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(cyc == e.at, {e.tag, " irq cycle"}, cyc, e.at);
                    check(int'(vector_o) == e.vec, {e.tag, " irq vector"}, int'(vector_o), e.vec);
                end
            end
        end
    end

    task automatic wr_bank(input bit hi, input logic [3:0] v);
        @(negedge clk);
        acc_i = v; wr_lo_i = !hi; wr_hi_i = hi;
        @(negedge clk);
        wr_lo_i = 1'b0; wr_hi_i = 1'b0;
    endtask

    task automatic rd_bank(input bit hi, output logic [3:0] v);
        @(negedge clk);
        rd_lo_i = !hi; rd_hi_i = hi;
        #1 v = acc_o;
        rd_lo_i = 1'b0; rd_hi_i = 1'b0;
    endtask

    task automatic skip_test(input int src, output logic v);
        @(negedge clk);
        skip_req_i = 1'b1; skip_src_i = 3'(src);
        #1 v = skip_o;
        @(posedge clk);
        #1 skip_req_i = 1'b0;
    endtask

    // Driver: request pulse, pushes an expected item when dly > 0
    task automatic pulse_req(input logic [6:0] m, input int dly, input int vec, input string tag);
        exp_t e;
        @(negedge clk);
        req_i = m;
        if (dly > 0) begin
            e.at = cyc + dly; e.vec = vec; e.tag = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic gie_pulse(input bit set, input int dly, input int vec, input string tag);
        exp_t e;
        @(negedge clk);
        gie_set_i = set; gie_clr_i = !set;
        if (dly > 0) begin
            e.at = cyc + dly; e.vec = vec; e.tag = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        gie_set_i = 1'b0; gie_clr_i = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_o) seen = 1'b1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        logic [3:0] v;
        logic       s;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd_bank(1'b0, v); check(v == 4'h0, "R1 low bank after reset", v, 0);
        rd_bank(1'b1, v); check(v == 4'h0, "R1 high bank after reset", v, 0);
        check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
        for (int k = 0; k < 7; k++) begin
            skip_test(k, s);
            check(s == 1'b0, "R1 no flag set after reset", s, 0);
        end

        // R2 / R3: bank write and read back
        wr_bank(1'b0, 4'b1010);
        rd_bank(1'b0, v); check(v == 4'b1010, "R2 low bank readback", v, 4'b1010);
        wr_bank(1'b1, 4'b1101);
        rd_bank(1'b1, v); check(v == 4'b1101, "R3 high bank readback incl bit3", v, 4'b1101);
        rd_bank(1'b0, v); check(v == 4'b1010, "R3 low bank unchanged", v, 4'b1010);
        wr_bank(1'b1, 4'b1000);
        rd_bank(1'b1, v); check(v == 4'b1000, "R3 spare bit alone", v, 4'b1000);

        // R4: retention clears and beats a write
        @(negedge clk);
        acc_i = 4'b1111; wr_lo_i = 1'b1; retain_i = 1'b1;
        @(negedge clk);
        wr_lo_i = 1'b0; retain_i = 1'b0;
        rd_bank(1'b0, v); check(v == 4'h0, "R4 low bank after retention", v, 0);
        rd_bank(1'b1, v); check(v == 4'h0, "R4 high bank after retention", v, 0);

        // R12 / R8: polled path with enable clear
        pulse_req(7'b000_1000, 0, 0, "");
        quiet(4, "R5 no irq with enable and gie off");
        skip_test(3, s); check(s == 1'b1, "R8 skip reports set flag", s, 1);
        skip_test(3, s); check(s == 1'b0, "R8 skip cleared the flag", s, 0);
        skip_test(2, s); check(s == 1'b0, "R12 untouched flag stays clear", s, 0);

        // R9: enabled source ignores skip test, keeps flag
        wr_bank(1'b0, 4'b0010);
        pulse_req(7'b000_0010, 0, 0, "");
        skip_test(1, s); check(s == 1'b0, "R9 skip invalid when enabled", s, 0);
        quiet(6, "R5 no irq while gie off");
        // R6: gie set with a pending enabled flag, one-cycle instruction
        gie_pulse(1'b1, 3, 1, "R6 short delay");
        idle(4);
        // R11: accepted flag cleared
        wr_bank(1'b0, 4'b0000);
        skip_test(1, s); check(s == 1'b0, "R11 winner flag cleared", s, 0);
        // R11: gie cleared by acceptance
        wr_bank(1'b0, 4'b0010);
        pulse_req(7'b000_0010, 0, 0, "");
        quiet(6, "R11 gie cleared after accept");
        wr_bank(1'b0, 4'b0000);
        skip_test(1, s); check(s == 1'b1, "R12 flag held until polled", s, 1);

        // R5: gie on but enable off
        gie_pulse(1'b1, 0, 0, "");
        pulse_req(7'b000_0001, 0, 0, "");
        quiet(6, "R5 no irq with enable bit clear");
        skip_test(0, s); check(s == 1'b1, "R8 polled ext0 flag", s, 1);
        gie_pulse(1'b0, 0, 0, "");

        // R7: multi-cycle instruction lengthens the wait
        wr_bank(1'b1, 4'b0100);
        gie_pulse(1'b1, 0, 0, "");
        multi_i = 1'b1;
        pulse_req(7'b100_0000, 4, 6, "R7 long delay");
        idle(6);
        multi_i = 1'b0;

        // R10: simultaneous sources, lowest index first, loser kept
        wr_bank(1'b0, 4'b1111);
        wr_bank(1'b1, 4'b0111);
        gie_pulse(1'b1, 0, 0, "");
        pulse_req(7'b010_0100, 3, 2, "R10 timer1 beats timer4");
        idle(5);
        gie_pulse(1'b1, 3, 5, "R10 timer4 follows");
        idle(5);
        gie_pulse(1'b1, 0, 0, "");
        pulse_req(7'b100_0001, 3, 0, "R10 ext0 beats converter");
        idle(5);
        gie_pulse(1'b1, 3, 6, "R10 converter follows");
        idle(6);

        check(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule